// File: doc/BRIEF.md
# Barrier-Aware Queue Dispatch Controller

This block decides, cycle by cycle, whether the packet at the head of one command queue may be dispatched. Two ordering mechanisms are honoured. A packet whose barrier bit is set blocks every later dispatch until the completion logic reports that the last packet still in flight has finished. A barrier packet blocks the queue until each of its non-null dependency signals has been read back as zero. The block reaches those signal values through a simple read request and response port. If any signal is not yet zero, the whole set is read again after a programmable pause. Only when all of them are zero does the barrier packet complete and the queue reopen.

A read round checks up to five dependency slots, one per cycle, in ascending order, and a counter tracks the responses still owed. When the queue is unmapped, blocking is dropped at once and the round is abandoned. Responses still owed are then taken in and thrown away. Dispatch stays off until the last of them has arrived, so a late value cannot leak into a later barrier.

Queue states: `QS_OPEN` (dispatch allowed), `QS_HOLD_BIT` (held by a barrier bit) and `QS_HOLD_BAR` (held by a barrier packet). Transitions:
- OPEN to HOLD_BIT: an ordinary packet with its barrier bit set is dispatched.
- OPEN to HOLD_BAR: a barrier packet is dispatched.
- HOLD_BIT to OPEN: a completion arrives together with the last-outstanding indication.
- HOLD_BAR to OPEN: a read round ends with every non-null signal equal to zero.
- Any state to OPEN: an unmap strobe.

Read engine states: `FS_IDLE`, `FS_SCAN` (one slot per cycle), `FS_WAIT` (responses owed) and `FS_BACKOFF` (pause before the next round).

Top module: `barrier_dispatch_ctrl`

## Requirements
- R1: After reset `queue_state` is 0, and `dispatch_en`, `rd_req_valid` and `barrier_done` are low.
- R2: `queue_state` encodes 0 = open, 1 = held by barrier bit, 2 = held by barrier packet. `pkt_type` encodes 0 = invalid, 1 = kernel, 2 = barrier packet, 3 = other ordinary packet.
- R3: `dispatch_en` is high exactly when the state is open, `pkt_valid` is high, `pkt_type` is not 0, `unmap` is low and no signal response is owed.
- R4: An ordinary packet (type 1 or 3) that is dispatched leaves the state open when its barrier bit is clear. When its barrier bit is set, the state is 1 from the next cycle.
- R5: In state 1, a completion without the last-outstanding indication, or that indication without a completion, changes nothing. A completion with the indication reopens the queue on the next cycle.
- R6: A dispatched barrier packet sets state 2 on the next cycle. In the following five cycles, slot k is presented on `rd_req_slot` in cycle k, and `rd_req_valid` is high only for slots whose `pkt_sig_mask` bit is 1.
- R7: When every response owed has arrived and every masked slot returned 0, `barrier_done` pulses for one cycle while the state is 2, and the state is 0 on the next cycle. Slots with mask bit 0 count as satisfied.
- R8: If any masked slot returned a nonzero value, `barrier_done` stays low. The state stays 2 and no request is made for `retry_wait`+1 cycles. A fresh round then starts with every slot again unsatisfied.
- R9: A barrier packet with an all-zero mask makes no request and completes after its five-cycle scan.
- R10: `unmap` forces state 0 on the next cycle and stops requests. Responses still owed are discarded without completing the barrier, and `dispatch_en` stays low until the last of them arrives.
- R11: A response arriving when none is owed changes neither the state nor `dispatch_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is waiting at the queue head |
| pkt_type | input | 2 | Head packet kind (R2 encoding) |
| pkt_bbit | input | 1 | Head packet barrier bit |
| pkt_sig_mask | input | NSIG (5) | Non-null dependency slots of a barrier packet |
| retry_wait | input | DLY_W (8) | Pause length between read rounds |
| pkt_done | input | 1 | A dispatched packet completed |
| pkt_last | input | 1 | The completing packet was the last one outstanding |
| rd_resp_valid | input | 1 | Signal read response strobe |
| rd_resp_slot | input | SLOT_W (3) | Slot the response belongs to |
| rd_resp_value | input | VAL_W (32) | Signal value read |
| unmap | input | 1 | Queue unmap strobe |
| dispatch_en | output | 1 | Head packet may be dispatched this cycle |
| queue_state | output | 2 | Blocking state (R2 encoding) |
| rd_req_valid | output | 1 | Signal read request strobe |
| rd_req_slot | output | SLOT_W (3) | Slot being requested |
| barrier_done | output | 1 | Barrier packet completed this cycle |

## Verification
Barrier packets are driven from a table of mask and response patterns: full masks with all zero replies, sparse masks, an empty mask, and masks where one reply is nonzero. These patterns separate correct slot skipping from a plain scan, the empty-mask shortcut from the read path, and the retry path with its exact pause from immediate completion. Directed sequences then present completion and last-outstanding strobes one at a time and together, to show that only the pair releases a barrier-bit hold. An unmap issued with three responses owed, followed by late replies and a stray reply, shows that discarded values neither complete a barrier nor reopen dispatch early.

// File: rtl/bqd_pkg.sv
package bqd_pkg;

    typedef enum logic [1:0] {
        QS_OPEN     = 2'd0,
        QS_HOLD_BIT = 2'd1,
        QS_HOLD_BAR = 2'd2
    } qstate_e;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_SCAN    = 2'd1,
        FS_WAIT    = 2'd2,
        FS_BACKOFF = 2'd3
    } fstate_e;

    localparam logic [1:0] PT_INVALID = 2'd0;
    localparam logic [1:0] PT_KERNEL  = 2'd1;
    localparam logic [1:0] PT_BARRIER = 2'd2;

endpackage

// File: rtl/bqd_pend_ctr.sv
module bqd_pend_ctr #(
    parameter int NSIG  = 5,
    localparam int CNT_W = $clog2(NSIG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             resp_valid,
    input  logic             abort,
    output logic             none_owed,
    output logic             resp_keep,
    output logic             discarding
);
    logic [CNT_W-1:0] count_q, count_n;
    logic             discard_q, discard_n;
    logic             take;

    always_comb begin
        take      = resp_valid && (count_q != '0);
        count_n   = count_q + CNT_W'(issue) - CNT_W'(take);
        if (abort) begin
            discard_n = (count_n != '0);
        end else begin
            discard_n = discard_q && (count_n != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            discard_q <= 1'b0;
        end else begin
            count_q   <= count_n;
            discard_q <= discard_n;
        end
    end

    assign none_owed  = (count_q == '0);
    assign resp_keep  = take && !discard_q;
    assign discarding = discard_q;

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(NSIG)); // R6
    AST_DISCARD_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        discard_q |-> (count_q != '0)); // R10
    AST_STRAY_NOCHG: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) && !issue |=> (count_q == '0)); // R11

endmodule

// File: rtl/bqd_sig_fetch.sv
module bqd_sig_fetch
    import bqd_pkg::*;
#(
    parameter int NSIG  = 5,
    parameter int VAL_W = 32,
    parameter int DLY_W = 8,
    localparam int SLOT_W = (NSIG > 1) ? $clog2(NSIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [NSIG-1:0]   mask_in,
    input  logic [DLY_W-1:0]  retry_wait,
    input  logic [SLOT_W-1:0] resp_slot,
    input  logic [VAL_W-1:0]  resp_value,
    input  logic              resp_keep,
    input  logic              none_owed,
    output logic              req_valid,
    output logic [SLOT_W-1:0] req_slot,
    output logic              round_ok
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSIG - 1);

    fstate_e           f_q, f_n;
    logic [SLOT_W-1:0] slot_q;
    logic [NSIG-1:0]   mask_q;
    logic [DLY_W-1:0]  wait_q;
    logic [NSIG-1:0]   zero_seen;
    logic              reload;
    logic              all_ok;

    always_comb begin
        f_n = f_q;
        unique case (f_q)
            FS_IDLE:    if (start) f_n = FS_SCAN;
            FS_SCAN:    if (slot_q == LAST_SLOT) f_n = FS_WAIT;
            FS_WAIT:    if (none_owed) f_n = all_ok ? FS_IDLE : FS_BACKOFF;
            FS_BACKOFF: if (wait_q == '0) f_n = FS_SCAN;
            default:    f_n = FS_IDLE;
        endcase
        if (abort) f_n = FS_IDLE;
    end

    assign reload = (f_n == FS_SCAN) && (f_q != FS_SCAN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= FS_IDLE;
            slot_q <= '0;
            mask_q <= '0;
            wait_q <= '0;
        end else begin
            f_q <= f_n;
            if (start && (f_q == FS_IDLE)) mask_q <= mask_in;
            if (reload) begin
                slot_q <= '0;
            end else if (f_q == FS_SCAN) begin
                slot_q <= slot_q + 1'b1;
            end
            if (f_q == FS_WAIT) begin
                wait_q <= retry_wait;
            end else if ((f_q == FS_BACKOFF) && (wait_q != '0)) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_slot
        logic z_q;
        always_ff @(posedge clk) begin
            if (!rst_n || reload) begin
                z_q <= 1'b0;
            end else if (resp_keep && (resp_slot == SLOT_W'(i))) begin
                z_q <= (resp_value == '0);
            end
        end
        assign zero_seen[i] = z_q;
    end

    assign all_ok    = &(~mask_q | zero_seen);
    assign req_valid = (f_q == FS_SCAN) && mask_q[slot_q];
    assign req_slot  = slot_q;
    assign round_ok  = (f_q == FS_WAIT) && none_owed && all_ok && !abort;

    AST_SCAN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q == FS_SCAN) && (slot_q != LAST_SLOT) && !abort |=> slot_q == $past(slot_q) + 1'b1); // R6
    AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q == FS_BACKOFF) |-> !req_valid && !round_ok); // R8

endmodule

// File: rtl/barrier_dispatch_ctrl.sv
module barrier_dispatch_ctrl
    import bqd_pkg::*;
#(
    parameter int NSIG  = 5,
    parameter int VAL_W = 32,
    parameter int DLY_W = 8,
    localparam int SLOT_W = (NSIG > 1) ? $clog2(NSIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [1:0]        pkt_type,
    input  logic              pkt_bbit,
    input  logic [NSIG-1:0]   pkt_sig_mask,
    input  logic [DLY_W-1:0]  retry_wait,
    input  logic              pkt_done,
    input  logic              pkt_last,
    input  logic              rd_resp_valid,
    input  logic [SLOT_W-1:0] rd_resp_slot,
    input  logic [VAL_W-1:0]  rd_resp_value,
    input  logic              unmap,
    output logic              dispatch_en,
    output logic [1:0]        queue_state,
    output logic              rd_req_valid,
    output logic [SLOT_W-1:0] rd_req_slot,
    output logic              barrier_done
);
    qstate_e state_q, state_n;
    logic    none_owed, resp_keep, discarding;
    logic    round_ok, start_fetch, fire;

    assign fire        = (state_q == QS_OPEN) && pkt_valid && (pkt_type != PT_INVALID)
                         && !unmap && none_owed;
    assign start_fetch = fire && (pkt_type == PT_BARRIER);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            QS_OPEN: begin
                if (fire) begin
                    if (pkt_type == PT_BARRIER) state_n = QS_HOLD_BAR;
                    else if (pkt_bbit)          state_n = QS_HOLD_BIT;
                end
            end
            QS_HOLD_BIT: if (pkt_done && pkt_last) state_n = QS_OPEN;
            QS_HOLD_BAR: if (round_ok)             state_n = QS_OPEN;
            default:     state_n = QS_OPEN;
        endcase
        if (unmap) state_n = QS_OPEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_OPEN;
        else        state_q <= state_n;
    end

    always_comb begin
        dispatch_en  = fire;
        queue_state  = state_q;
        barrier_done = round_ok && (state_q == QS_HOLD_BAR);
    end

    bqd_pend_ctr #(.NSIG(NSIG)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (rd_req_valid),
        .resp_valid (rd_resp_valid),
        .abort      (unmap),
        .none_owed  (none_owed),
        .resp_keep  (resp_keep),
        .discarding (discarding)
    );

    bqd_sig_fetch #(.NSIG(NSIG), .VAL_W(VAL_W), .DLY_W(DLY_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_fetch),
        .abort      (unmap),
        .mask_in    (pkt_sig_mask),
        .retry_wait (retry_wait),
        .resp_slot  (rd_resp_slot),
        .resp_value (rd_resp_value),
        .resp_keep  (resp_keep),
        .none_owed  (none_owed),
        .req_valid  (rd_req_valid),
        .req_slot   (rd_req_slot),
        .round_ok   (round_ok)
    );

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_HOLD_BIT) && !(pkt_done && pkt_last) && !unmap |=> state_q == QS_HOLD_BIT); // R5
    AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_HOLD_BAR) && !barrier_done && !unmap |=> state_q == QS_HOLD_BAR); // R7
    AST_REQ_IN_BAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> state_q == QS_HOLD_BAR); // R6
    AST_UNMAP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        unmap |=> state_q == QS_OPEN && !rd_req_valid); // R10
    AST_DONE_IN_BAR: assert property (@(posedge clk) disable iff (!rst_n)
        round_ok |-> state_q == QS_HOLD_BAR); // R7
    AST_NO_FIRE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        discarding |-> !dispatch_en); // R10

endmodule

// File: tb/barrier_dispatch_ctrl_tb.sv
module barrier_dispatch_ctrl_tb_top;
    localparam int W = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pkt_valid, pkt_bbit, pkt_done, pkt_last, rd_resp_valid, unmap;
    logic [1:0]  pkt_type;
    logic [4:0]  pkt_sig_mask;
    logic [7:0]  retry_wait;
    logic [2:0]  rd_resp_slot, rd_req_slot;
    logic [31:0] rd_resp_value;
    logic        dispatch_en, rd_req_valid, barrier_done;
    logic [1:0]  queue_state;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    barrier_dispatch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
        .pkt_bbit(pkt_bbit), .pkt_sig_mask(pkt_sig_mask), .retry_wait(retry_wait),
        .pkt_done(pkt_done), .pkt_last(pkt_last), .rd_resp_valid(rd_resp_valid),
        .rd_resp_slot(rd_resp_slot), .rd_resp_value(rd_resp_value), .unmap(unmap),
        .dispatch_en(dispatch_en), .queue_state(queue_state), .rd_req_valid(rd_req_valid),
        .rd_req_slot(rd_req_slot), .barrier_done(barrier_done)
    );

    // rows: {mask, zero_reply_mask}
    localparam logic [9:0] BAR_TAB [6] = '{
        {5'b11111, 5'b11111},
        {5'b10101, 5'b10101},
        {5'b00000, 5'b00000},
        {5'b01000, 5'b00000},
        {5'b11111, 5'b11011},
        {5'b00010, 5'b00010}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic scan(input logic [4:0] m);
        for (int i = 0; i < 5; i++) begin
            chk("R6 req valid", rd_req_valid, m[i]);
            if (m[i]) chk("R6 req slot", rd_req_slot, i);
            chk("R2 state held by barrier", queue_state, 2);
            step();
        end
    endtask

    task automatic reply(input logic [4:0] m, input logic [4:0] z);
        for (int i = 0; i < 5; i++) begin
            if (m[i]) begin
                rd_resp_valid = 1'b1;
                rd_resp_slot  = 3'(i);
                rd_resp_value = z[i] ? 32'd0 : 32'hFFFF_0005;
                step();
                rd_resp_valid = 1'b0;
            end
        end
    endtask

    task automatic run_barrier(input logic [4:0] m, input logic [4:0] z);
        pkt_valid = 1'b1; pkt_type = 2'd2; pkt_bbit = 1'b0; pkt_sig_mask = m;
        #1 chk("R3 barrier dispatch_en", dispatch_en, 1);
        step();
        pkt_valid = 1'b0;
        scan(m);
        if (m == 5'b0) begin
            chk("R9 empty mask done", barrier_done, 1);
            step();
            chk("R9 empty mask reopen", queue_state, 0);
            return;
        end
        chk("R7 no done while owed", barrier_done, 0);
        reply(m, z);
        if ((m & ~z) == 5'b0) begin
            chk("R7 done pulse", barrier_done, 1);
            step();
            chk("R7 reopen", queue_state, 0);
            chk("R7 pulse ends", barrier_done, 0);
        end else begin
            chk("R8 no done on nonzero", barrier_done, 0);
            for (int k = 1; k <= W + 2; k++) begin
                step();
                if (k <= W + 1) begin
                    chk("R8 quiet backoff", rd_req_valid, 0);
                    chk("R8 held in backoff", queue_state, 2);
                end
            end
            scan(m);
            chk("R8 fresh round not done", barrier_done, 0);
            reply(m, m);
            chk("R8 retry done", barrier_done, 1);
            step();
            chk("R8 reopen after retry", queue_state, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pkt_valid = 1'b0; pkt_type = 2'd0; pkt_bbit = 1'b0;
        pkt_sig_mask = '0; retry_wait = 8'(W); pkt_done = 1'b0; pkt_last = 1'b0;
        rd_resp_valid = 1'b0; rd_resp_slot = '0; rd_resp_value = '0; unmap = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", queue_state, 0);
        chk("R1 reset dispatch_en", dispatch_en, 0);
        chk("R1 reset req", rd_req_valid, 0);
        chk("R1 reset done", barrier_done, 0);
        rst_n = 1'b1;
        step();

        for (int r = 0; r < 6; r++) run_barrier(BAR_TAB[r][9:5], BAR_TAB[r][4:0]);

        // R3 invalid type never dispatched
        pkt_valid = 1'b1; pkt_type = 2'd0; pkt_bbit = 1'b1;
        #1 chk("R3 invalid type", dispatch_en, 0);
        step();
        chk("R3 invalid keeps open", queue_state, 0);

        // R4 kernel without barrier bit
        pkt_type = 2'd1; pkt_bbit = 1'b0;
        #1 chk("R3 kernel dispatch_en", dispatch_en, 1);
        step();
        chk("R4 no bbit stays open", queue_state, 0);
        chk("R4 next dispatch allowed", dispatch_en, 1);

        // R4/R5 kernel with barrier bit
        pkt_bbit = 1'b1;
        step();
        chk("R4 bbit holds", queue_state, 1);
        chk("R5 held blocks dispatch", dispatch_en, 0);
        pkt_done = 1'b1; pkt_last = 1'b0;
        step();
        chk("R5 done without last", queue_state, 1);
        pkt_done = 1'b0; pkt_last = 1'b1;
        step();
        chk("R5 last without done", queue_state, 1);
        pkt_done = 1'b1; pkt_last = 1'b1;
        step();
        pkt_done = 1'b0; pkt_last = 1'b0; pkt_valid = 1'b0;
        chk("R5 release", queue_state, 0);

        // R4 other ordinary type with bbit, then R10 unmap from hold
        pkt_valid = 1'b1; pkt_type = 2'd3; pkt_bbit = 1'b1;
        step();
        pkt_valid = 1'b0;
        chk("R4 type3 bbit holds", queue_state, 1);
        unmap = 1'b1;
        step();
        unmap = 1'b0;
        chk("R10 unmap from bit hold", queue_state, 0);

        // R10 unmap with three responses owed
        pkt_valid = 1'b1; pkt_type = 2'd2; pkt_bbit = 1'b0; pkt_sig_mask = 5'b00111;
        step();
        pkt_valid = 1'b0;
        scan(5'b00111);
        unmap = 1'b1;
        step();
        unmap = 1'b0;
        chk("R10 state open", queue_state, 0);
        chk("R10 no requests", rd_req_valid, 0);
        pkt_valid = 1'b1; pkt_type = 2'd1; pkt_bbit = 1'b0;
        #1 chk("R10 dispatch blocked while owed", dispatch_en, 0);
        for (int i = 0; i < 3; i++) begin
            rd_resp_valid = 1'b1; rd_resp_slot = 3'(i); rd_resp_value = 32'd0;
            #1 chk("R10 no barrier done", barrier_done, 0);
            step();
            rd_resp_valid = 1'b0;
            #1 chk("R10 dispatch after drain", dispatch_en, (i == 2) ? 1 : 0);
        end
        pkt_valid = 1'b0;

        // R11 stray response
        rd_resp_valid = 1'b1; rd_resp_slot = 3'd1; rd_resp_value = 32'd7;
        step();
        rd_resp_valid = 1'b0;
        chk("R11 stray state", queue_state, 0);
        pkt_valid = 1'b1; pkt_type = 2'd1;
        #1 chk("R11 stray dispatch_en", dispatch_en, 1);
        pkt_valid = 1'b0;
        run_barrier(5'b00011, 5'b00011);

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule